// File: doc/BRIEF.md
# Segmented LRU Replacement Controller

This block holds the replacement state for a single set of a WAYS-way cache. The ways are split between two groups: a probationary group, which newly filled lines enter, and a protected group, which lines reach by being hit while resident. Each group keeps its lines ordered from most to least recently touched. The protected group may hold at most `PROT_LIMIT` lines. When a promotion would push it past that limit, its oldest line drops back to the newest position of the probationary group, so it gets another chance before eviction.

The surrounding cache does the tag compare. Each cycle it may present one access: a strobe, a hit flag, and on a hit the way that matched. The block always shows the way that the next miss would replace, as a combinational output of the current state. On a miss access the block installs the fill into that way. Per-way valid and segment flags and the protected occupancy count are outputs, so the set's state can be seen.

Internally one recency rank per way orders all ways together. The order inside a segment is the rank order restricted to that segment's ways. A fill or a touch moves one way to rank 0. A promotion that forces a demotion places the promoted way at rank 0 and the demoted way at rank 1.

Top module: `slru_set_ctrl`

## Requirements
- R1: A synchronous active-high reset makes every way invalid and probationary, sets the protected count to 0, and leaves way 0 as the victim.
- R2: While any way is invalid, the victim output names the invalid way with the lowest index. It is combinational from the current state.
- R3: An access with `acc_valid`=1 and `acc_hit`=0 installs into the current victim way. On the next cycle that way is valid, probationary, and the most recently used line of the probationary segment.
- R4: A hit on a valid probationary way while the protected count is below `PROT_LIMIT` moves that way to the most-recently-used end of the protected segment and raises the count by one.
- R5: A hit on a valid probationary way while the protected count equals `PROT_LIMIT` promotes that way to protected MRU. It also demotes the least recently used protected way to probationary MRU, and the count does not change.
- R6: A hit on a valid protected way only makes it the protected MRU line. No way changes segment and the count does not change.
- R7: When every way is valid and at least one is probationary, the victim is the least recently used probationary way.
- R8: When every valid way is protected, the victim is the least recently used protected way. Filling it makes it probationary and lowers the count by one.
- R9: A cycle with `acc_valid`=0, or a hit on a way that is invalid, changes no state.
- R10: The protected count always equals the number of valid protected ways and never exceeds `PROT_LIMIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_hit | input | 1 | 1: the access hit `acc_way`; 0: miss, fill the victim |
| acc_way | input | $clog2(WAYS) | Way that matched on a hit |
| victim_way | output | $clog2(WAYS) | Way the next miss replaces |
| way_valid | output | WAYS | Per-way valid flag |
| way_prot | output | WAYS | Per-way segment flag, 1 = protected |
| prot_count | output | $clog2(WAYS+1) | Number of protected ways |

## Verification
The assertions assume a few things about the inputs. `acc_way` names an existing way, which always holds when WAYS is a power of two. `PROT_LIMIT` lies between 1 and WAYS. A hit flag is trusted as the result of a correct tag compare, so the block does not check whether the line really matches. The stimulus changes inputs only on falling edges and keeps `acc_way` in range. It sends hits to invalid ways only on purpose, to show they are ignored. A second instance with the limit equal to WAYS reaches the state in which every valid line is protected.

// File: rtl/slru_pkg.sv
package slru_pkg;

    typedef enum logic {
        SEG_PROB = 1'b0,
        SEG_PROT = 1'b1
    } seg_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FILL,
        OP_TOUCH,
        OP_PROMOTE,
        OP_SWAP
    } op_e;

    typedef struct packed {
        logic valid;
        seg_e seg;
    } way_state_t;

endpackage

// File: rtl/slru_oldest.sv
module slru_oldest #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]         mask,
    input  logic [N-1:0][IW-1:0] age,
    output logic                 found,
    output logic [IW-1:0]        idx
);
    logic [IW-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (!found || age[i] > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = age[i];
            end
        end
    end
endmodule

// File: rtl/slru_rank_update.sv
module slru_rank_update #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0][IW-1:0] age_q,
    input  logic                 mv0_en,
    input  logic [IW-1:0]        mv0_idx,
    input  logic                 mv1_en,
    input  logic [IW-1:0]        mv1_idx,
    output logic [N-1:0][IW-1:0] age_d
);
    logic [IW-1:0] age0;
    logic [IW-1:0] age1;

    assign age0 = age_q[mv0_idx];
    assign age1 = age_q[mv1_idx];

    for (genvar w = 0; w < N; w++) begin : g_rank
        logic inc0;
        logic inc1;
        assign inc0 = mv0_en && (age0 > age_q[w]);
        assign inc1 = mv1_en && (age1 > age_q[w]);
        always_comb begin
            if (mv0_en && mv0_idx == IW'(w))
                age_d[w] = '0;
            else if (mv1_en && mv1_idx == IW'(w))
                age_d[w] = IW'(1);
            else
                age_d[w] = age_q[w] + IW'(inc0) + IW'(inc1);
        end
    end
endmodule

// File: rtl/slru_set_ctrl.sv
module slru_set_ctrl
    import slru_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int PROT_LIMIT = 2,
    localparam int IW = $clog2(WAYS),
    localparam int CW = $clog2(WAYS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic            acc_hit,
    input  logic [IW-1:0]   acc_way,
    output logic [IW-1:0]   victim_way,
    output logic [WAYS-1:0] way_valid,
    output logic [WAYS-1:0] way_prot,
    output logic [CW-1:0]   prot_count
);
    way_state_t [WAYS-1:0]         st_q;
    logic       [WAYS-1:0][IW-1:0] age_q;
    logic       [WAYS-1:0][IW-1:0] age_d;
    logic       [CW-1:0]           cnt_q;

    logic [WAYS-1:0] prob_mask;
    logic [WAYS-1:0] prot_mask;
    logic            prob_found;
    logic [IW-1:0]   prob_lru;
    logic            prot_found;
    logic [IW-1:0]   prot_lru;
    logic            inv_found;
    logic [IW-1:0]   inv_idx;
    logic [IW-1:0]   victim;
    op_e             op;
    logic            at_limit;

    for (genvar i = 0; i < WAYS; i++) begin : g_flags
        assign prob_mask[i] = st_q[i].valid && (st_q[i].seg == SEG_PROB);
        assign prot_mask[i] = st_q[i].valid && (st_q[i].seg == SEG_PROT);
        assign way_valid[i] = st_q[i].valid;
        assign way_prot[i]  = (st_q[i].seg == SEG_PROT);
    end

    slru_oldest #(.N(WAYS), .IW(IW)) u_prob_lru (
        .mask  (prob_mask),
        .age   (age_q),
        .found (prob_found),
        .idx   (prob_lru)
    );

    slru_oldest #(.N(WAYS), .IW(IW)) u_prot_lru (
        .mask  (prot_mask),
        .age   (age_q),
        .found (prot_found),
        .idx   (prot_lru)
    );

    always_comb begin
        inv_found = 1'b0;
        inv_idx   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!st_q[i].valid) begin
                inv_found = 1'b1;
                inv_idx   = IW'(i);
            end
        end
    end

    always_comb begin
        if (inv_found)
            victim = inv_idx;
        else if (prob_found)
            victim = prob_lru;
        else
            victim = prot_lru;
    end

    assign victim_way = victim;
    assign prot_count = cnt_q;
    assign at_limit   = (int'(cnt_q) >= PROT_LIMIT) && prot_found;

    always_comb begin
        op = OP_NONE;
        if (acc_valid && !acc_hit)
            op = OP_FILL;
        else if (acc_valid && st_q[acc_way].valid) begin
            if (st_q[acc_way].seg == SEG_PROT)
                op = OP_TOUCH;
            else if (at_limit)
                op = OP_SWAP;
            else
                op = OP_PROMOTE;
        end
    end

    slru_rank_update #(.N(WAYS), .IW(IW)) u_rank (
        .age_q   (age_q),
        .mv0_en  (op != OP_NONE),
        .mv0_idx ((op == OP_FILL) ? victim : acc_way),
        .mv1_en  (op == OP_SWAP),
        .mv1_idx (prot_lru),
        .age_d   (age_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WAYS; i++) begin
                st_q[i]  <= '{valid: 1'b0, seg: SEG_PROB};
                age_q[i] <= IW'(i);
            end
            cnt_q <= '0;
        end else begin
            age_q <= age_d;
            case (op)
                OP_FILL: begin
                    st_q[victim] <= '{valid: 1'b1, seg: SEG_PROB};
                    if (prot_mask[victim])
                        cnt_q <= cnt_q - CW'(1);
                end
                OP_PROMOTE: begin
                    st_q[acc_way].seg <= SEG_PROT;
                    cnt_q             <= cnt_q + CW'(1);
                end
                OP_SWAP: begin
                    st_q[acc_way].seg  <= SEG_PROT;
                    st_q[prot_lru].seg <= SEG_PROB;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/slru_set_chk.sv
module slru_set_chk #(
    parameter int WAYS       = 4,
    parameter int PROT_LIMIT = 2,
    parameter int IW         = 2,
    parameter int CW         = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            acc_valid,
    input logic            acc_hit,
    input logic [IW-1:0]   acc_way,
    input logic [IW-1:0]   victim_way,
    input logic [WAYS-1:0] way_valid,
    input logic [WAYS-1:0] way_prot,
    input logic [CW-1:0]   prot_count
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (way_valid == '0 && way_prot == '0 && prot_count == '0));

    p_invalid_first_r2: assert property (@(posedge clk) disable iff (rst)
        !(&way_valid) |-> !way_valid[victim_way]);

    p_fill_prob_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_hit) |=>
            (way_valid[$past(victim_way)] && !way_prot[$past(victim_way)]));

    p_promote_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_hit && way_valid[acc_way]) |=> way_prot[$past(acc_way)]);

    p_full_count_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_hit && int'(prot_count) == PROT_LIMIT) |=>
            (prot_count == $past(prot_count)));

    p_victim_prob_r7: assert property (@(posedge clk) disable iff (rst)
        ((&way_valid) && |(~way_prot)) |-> !way_prot[victim_way]);

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> ($stable(way_valid) && $stable(way_prot) && $stable(prot_count)));

    p_count_match_r10: assert property (@(posedge clk) disable iff (rst)
        int'(prot_count) == $countones(way_valid & way_prot));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        int'(prot_count) <= PROT_LIMIT);
endmodule

bind slru_set_ctrl slru_set_chk #(
    .WAYS(WAYS), .PROT_LIMIT(PROT_LIMIT), .IW(IW), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_hit    (acc_hit),
    .acc_way    (acc_way),
    .victim_way (victim_way),
    .way_valid  (way_valid),
    .way_prot   (way_prot),
    .prot_count (prot_count)
);

// File: tb/sim_slru_set_ctrl.sv
`timescale 1ns/1ps
module sim_slru_set_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_hit = 1'b0;
    logic [1:0] acc_way = '0;

    logic [1:0] vic0, vic1;
    logic [3:0] val0, val1, prt0, prt1;
    logic [2:0] cnt0, cnt1;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    slru_set_ctrl #(.WAYS(4), .PROT_LIMIT(2)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .victim_way(vic0), .way_valid(val0),
        .way_prot(prt0), .prot_count(cnt0)
    );

    slru_set_ctrl #(.WAYS(4), .PROT_LIMIT(4)) u1 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .victim_way(vic1), .way_valid(val1),
        .way_prot(prt1), .prot_count(cnt1)
    );

    // {valid, hit, way[1:0], victim[1:0], prot[3:0], valid[3:0], count[2:0]}
    localparam logic [16:0] VEC [15] = '{
        17'b1_0_00_01_0000_0001_000, // miss -> way0, next invalid way1 (R2)
        17'b1_0_00_10_0000_0011_000, // miss -> way1 (R2)
        17'b1_0_00_11_0000_0111_000, // miss -> way2 (R2)
        17'b1_0_00_00_0000_1111_000, // miss -> way3, full (R3)
        17'b1_1_01_00_0010_1111_001, // hit way1, promote (R4)
        17'b1_1_00_10_0011_1111_010, // hit way0, promote to limit (R4)
        17'b1_1_11_10_1001_1111_010, // hit way3, way1 demoted (R5)
        17'b1_1_00_10_1001_1111_010, // hit protected way0 (R6)
        17'b1_0_00_01_1001_1111_010, // miss -> LRU prob way2 (R7)
        17'b0_0_00_01_1001_1111_010, // idle (R9)
        17'b1_1_10_01_0101_1111_010, // hit way2, way3 demoted (R5)
        17'b1_0_00_11_0101_1111_010, // miss -> way1 (R7)
        17'b1_1_01_11_0110_1111_010, // hit way1, way0 demoted (R5)
        17'b1_1_11_00_1010_1111_010, // hit way3, way2 demoted (R5)
        17'b1_1_00_10_1001_1111_010  // hit way0, way1 demoted (R5)
    };

    function automatic string row_tag(int i);
        case (i)
            0, 1, 2:              return "R2";
            3:                    return "R3";
            4, 5:                 return "R4";
            7:                    return "R6";
            8, 11:                return "R7";
            9:                    return "R9";
            default:              return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic h, input logic [1:0] w);
        acc_valid = v;
        acc_hit   = h;
        acc_way   = w;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_hit   = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state of u0
        check("R1", {17'b0, vic0, prt0, val0, cnt0}, 32'h0);

        for (int i = 0; i < 15; i++) begin
            logic [16:0] e;
            e = VEC[i];
            step(e[16], e[15], e[14:13]);
            check(row_tag(i), {21'b0, vic0, prt0, val0}, {21'b0, e[12:11], e[10:7], e[6:3]});
            check("R10", {29'b0, cnt0}, {29'b0, e[2:0]});
        end

        do_reset();
        check("R1", {17'b0, vic0, prt0, val0, cnt0}, 32'h0);
        // R9: hit on an invalid way is ignored
        step(1'b1, 1'b1, 2'd2);
        check("R9", {17'b0, vic0, prt0, val0, cnt0}, 32'h0);
        check("R9", {17'b0, vic1, prt1, val1, cnt1}, 32'h0);

        // R8: with the limit at 4 (u1), every line becomes protected
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 2'd0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 2'(k));
        check("R8", {21'b0, vic1, prt1, val1}, {21'b0, 2'd0, 4'b1111, 4'b1111});
        check("R8", {29'b0, cnt1}, 32'd4);
        step(1'b1, 1'b0, 2'd0);
        check("R8", {21'b0, vic1, prt1, val1}, {21'b0, 2'd0, 4'b1110, 4'b1111});
        check("R8", {29'b0, cnt1}, 32'd3);
        // R6 on u1: hit protected way3 moves nothing between segments
        step(1'b1, 1'b1, 2'd3);
        check("R6", {20'b0, vic1, prt1, val1, cnt1}, {20'b0, 2'd0, 4'b1110, 4'b1111, 3'd3});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule